// File: doc/BRIEF.md
# Watch-Mode Power Sequencer

This block is the power-mode sequencer of a small microcontroller. It holds the chip's run mode and acts on a sleep strobe from the CPU. When every control bit agrees, the strobe puts the chip into a watch state. In that state only the watchdog-style timer and the sub-clock oscillator keep running; the CPU and all other peripherals lose their clocks but keep their contents. When the control bits do not agree, the strobe only halts the CPU in an ordinary sleep state.

Only unmasked interrupt sources wake the chip from watch. The target mode depends on the low-speed wake bit and the clock divider field, both sampled at the wake. A return to high speed first counts out a programmable oscillator settling time. After that the block releases the CPU and gives a one-cycle start-exception pulse. The hardware-standby pin and the reset pins override every mode.

Mode encoding on `mode_o`: 0 high-speed, 1 medium-speed, 2 subactive, 3 sleep, 4 watch, 5 settling, 6 hardware standby, 7 reset.

Top module: `wmode_seq`

## Requirements
- R1: While `sys_rst_n_i` is low, `mode_o` is 7 (reset) and `exc_start_o` is 0. The first clock edge after release, with both other override pins high, gives mode 0 (high-speed).
- R2: A sleep strobe in mode 0 or 2 enters mode 4 (watch) at the next edge only if all of these hold: `stby_sel_i`=1, `direct_xfer_i`=0, `tmr_clk_sel_i`=1 and `clk_div_i`=0.
- R3: A sleep strobe in mode 0, 1 or 2 that does not meet R2 enters mode 3 (sleep) at the next edge.
- R4: The outputs {cpu_clk_en, per_clk_en, wdt_clk_en, subosc_en, cpu_halt} follow the mode. Modes 0/1/2 give 11110. Mode 3 gives 01111. Modes 4 and 5 give 00111. Mode 6 gives 00001. Mode 7 gives 00011.
- R5: A wake needs one of three sources: `nmi_i`, which no mask blocks; an `irq_i` line whose own `irq_en_i` bit is 1; or `tmr_ovf_i` with `tmr_ovf_ie_i`=1. The last two count only while `int_mask_i`=0. Any other input pattern leaves mode 3 or 4 unchanged.
- R6: A wake from watch goes to mode 2 when `low_speed_wake_i`=1. Otherwise it goes to mode 1 when `clk_div_i`≠0, and to mode 5 (settling) when `clk_div_i`=0. Modes 1 and 2 are reached with `exc_start_o`=1 in the same cycle.
- R7: The block stays in mode 5 for exactly 8·2^`settle_sel_i` cycles, with `settle_sel_i` sampled at the wake. It then enters mode 0 with `exc_start_o`=1.
- R8: A wake from sleep returns at the next edge to the run mode that issued the strobe, with `exc_start_o`=1. The settling time and the low-speed bit play no part in this.
- R9: `hw_stby_n_i` low gives mode 6 at the next edge from any mode, and the block stays there while the pin is low. Once the pin is high, the block goes to mode 7 and then to mode 0.
- R10: `aux_rst_n_i` low gives mode 7 at the next edge from any mode, including watch. The first edge with the pin high again gives mode 0.
- R11: `exc_start_o` is never high for two cycles in a row. Interrupts and sleep strobes during mode 5 do not change the length of the settling time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running reference clock |
| sys_rst_n_i | input | 1 | Asynchronous system reset pin, active low |
| aux_rst_n_i | input | 1 | Second reset pin, synchronous, active low |
| hw_stby_n_i | input | 1 | Hardware-standby pin, active low |
| sleep_i | input | 1 | Sleep strobe from the CPU |
| stby_sel_i | input | 1 | Standby-select control bit |
| direct_xfer_i | input | 1 | Direct-transfer control bit |
| tmr_clk_sel_i | input | 1 | Timer clock-select control bit |
| low_speed_wake_i | input | 1 | Wake into subactive when 1 |
| clk_div_i | input | DIV_W | System clock divider field |
| settle_sel_i | input | SEL_W | Settling-time select |
| irq_i | input | IRQ_N | External interrupt lines |
| irq_en_i | input | IRQ_N | Per-line interrupt enables |
| tmr_ovf_i | input | 1 | Timer overflow interrupt request |
| tmr_ovf_ie_i | input | 1 | Timer overflow interrupt enable |
| nmi_i | input | 1 | Non-maskable interrupt |
| int_mask_i | input | 1 | CPU interrupt mask |
| mode_o | output | 3 | Current mode code |
| cpu_clk_en_o | output | 1 | CPU clock enable |
| per_clk_en_o | output | 1 | General peripheral clock enable |
| wdt_clk_en_o | output | 1 | Watchdog-style timer clock enable |
| subosc_en_o | output | 1 | Sub-clock oscillator enable |
| cpu_halt_o | output | 1 | CPU halt |
| exc_start_o | output | 1 | One-cycle start-exception pulse |

## Verification
The hardest case to reach from the ports is a strobe from subactive or medium-speed mode. Those modes exist only after a wake from watch, so each random trial first forces reset and then runs a full watch entry and wake to land in its start mode. Only after that does it apply random control bits and a second strobe. The longest settling window is 1024 cycles. It is measured cycle by cycle while new interrupt requests and strobes keep arriving, so any restart of the count shows up as a wrong length.

// File: rtl/wmode_pkg.sv
package wmode_pkg;

    typedef enum logic [2:0] {
        M_HIGH   = 3'd0,
        M_MED    = 3'd1,
        M_SUB    = 3'd2,
        M_SLEEP  = 3'd3,
        M_WATCH  = 3'd4,
        M_SETTLE = 3'd5,
        M_HWSTBY = 3'd6,
        M_RESET  = 3'd7
    } mode_e;

    typedef struct packed {
        mode_e mode;
        mode_e ret;
        logic  exc;
    } seq_state_t;

endpackage

// File: rtl/wmode_entry.sv
module wmode_entry
    import wmode_pkg::*;
#(
    parameter int DIV_W = 3
) (
    input  mode_e            mode_i,
    input  logic             stby_sel_i,
    input  logic             direct_xfer_i,
    input  logic             tmr_clk_sel_i,
    input  logic [DIV_W-1:0] clk_div_i,
    output logic             run_o,
    output logic             watch_ok_o
);
    logic fast_or_sub;
    logic bits_ok;

    always_comb begin
        fast_or_sub = (mode_i == M_HIGH) || (mode_i == M_SUB);
        run_o       = fast_or_sub || (mode_i == M_MED);
        bits_ok     = stby_sel_i && !direct_xfer_i && tmr_clk_sel_i
                      && (clk_div_i == '0);
        watch_ok_o  = fast_or_sub && bits_ok;
    end

endmodule

// File: rtl/wmode_wake.sv
module wmode_wake #(
    parameter int IRQ_N = 8
) (
    input  logic [IRQ_N-1:0] irq_i,
    input  logic [IRQ_N-1:0] irq_en_i,
    input  logic             tmr_ovf_i,
    input  logic             tmr_ovf_ie_i,
    input  logic             nmi_i,
    input  logic             mask_i,
    output logic             wake_o
);
    logic [IRQ_N-1:0] line_hit;
    logic             tmr_hit;

    for (genvar i = 0; i < IRQ_N; i++) begin : g_line
        assign line_hit[i] = irq_i[i] & irq_en_i[i] & ~mask_i;
    end

    assign tmr_hit = tmr_ovf_i & tmr_ovf_ie_i & ~mask_i;
    assign wake_o  = nmi_i | (|line_hit) | tmr_hit;

endmodule

// File: rtl/wmode_settle.sv
module wmode_settle #(
    parameter int BASE  = 8,
    parameter int SEL_W = 3
) (
    input  logic             clk_i,
    input  logic             rst_n_i,
    input  logic             load_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic             done_o
);
    localparam int MAX_SPAN = BASE << ((1 << SEL_W) - 1);
    localparam int CNT_W    = $clog2(MAX_SPAN);

    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic [CNT_W:0]   span;

    always_comb begin
        span  = (CNT_W+1)'(BASE) << sel_i;
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = CNT_W'(span - (CNT_W+1)'(1));
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - CNT_W'(1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign done_o = (cnt_q == '0);

    // R7: a fresh load never reads as finished in the following cycle unless the span is one
    p_load_busy_r7: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (load_i && (span > (CNT_W+1)'(1))) |=> !done_o);

endmodule

// File: rtl/wmode_seq.sv
module wmode_seq
    import wmode_pkg::*;
#(
    parameter int IRQ_N       = 8,
    parameter int DIV_W       = 3,
    parameter int SEL_W       = 3,
    parameter int SETTLE_BASE = 8
) (
    input  logic             clk_i,
    input  logic             sys_rst_n_i,
    input  logic             aux_rst_n_i,
    input  logic             hw_stby_n_i,
    input  logic             sleep_i,
    input  logic             stby_sel_i,
    input  logic             direct_xfer_i,
    input  logic             tmr_clk_sel_i,
    input  logic             low_speed_wake_i,
    input  logic [DIV_W-1:0] clk_div_i,
    input  logic [SEL_W-1:0] settle_sel_i,
    input  logic [IRQ_N-1:0] irq_i,
    input  logic [IRQ_N-1:0] irq_en_i,
    input  logic             tmr_ovf_i,
    input  logic             tmr_ovf_ie_i,
    input  logic             nmi_i,
    input  logic             int_mask_i,
    output logic [2:0]       mode_o,
    output logic             cpu_clk_en_o,
    output logic             per_clk_en_o,
    output logic             wdt_clk_en_o,
    output logic             subosc_en_o,
    output logic             cpu_halt_o,
    output logic             exc_start_o
);
    seq_state_t st_d, st_q;
    logic       run_now;
    logic       watch_ok;
    logic       wake;
    logic       settle_done;
    logic       settle_load;

    wmode_entry #(.DIV_W(DIV_W)) entry_i (
        .mode_i        (st_q.mode),
        .stby_sel_i    (stby_sel_i),
        .direct_xfer_i (direct_xfer_i),
        .tmr_clk_sel_i (tmr_clk_sel_i),
        .clk_div_i     (clk_div_i),
        .run_o         (run_now),
        .watch_ok_o    (watch_ok)
    );

    wmode_wake #(.IRQ_N(IRQ_N)) wake_i (
        .irq_i        (irq_i),
        .irq_en_i     (irq_en_i),
        .tmr_ovf_i    (tmr_ovf_i),
        .tmr_ovf_ie_i (tmr_ovf_ie_i),
        .nmi_i        (nmi_i),
        .mask_i       (int_mask_i),
        .wake_o       (wake)
    );

    wmode_settle #(.BASE(SETTLE_BASE), .SEL_W(SEL_W)) settle_i (
        .clk_i   (clk_i),
        .rst_n_i (sys_rst_n_i),
        .load_i  (settle_load),
        .sel_i   (settle_sel_i),
        .done_o  (settle_done)
    );

    always_comb begin
        st_d        = st_q;
        st_d.exc    = 1'b0;
        settle_load = 1'b0;
        if (!hw_stby_n_i) begin
            st_d.mode = M_HWSTBY;
        end else if ((st_q.mode == M_HWSTBY) || !aux_rst_n_i) begin
            st_d.mode = M_RESET;
        end else if (run_now) begin
            if (sleep_i) begin
                st_d.ret  = st_q.mode;
                st_d.mode = watch_ok ? M_WATCH : M_SLEEP;
            end
        end else begin
            unique case (st_q.mode)
                M_RESET: st_d.mode = M_HIGH;
                M_SLEEP: begin
                    if (wake) begin
                        st_d.mode = st_q.ret;
                        st_d.exc  = 1'b1;
                    end
                end
                M_WATCH: begin
                    if (wake) begin
                        if (low_speed_wake_i) begin
                            st_d.mode = M_SUB;
                            st_d.exc  = 1'b1;
                        end else if (clk_div_i != '0) begin
                            st_d.mode = M_MED;
                            st_d.exc  = 1'b1;
                        end else begin
                            st_d.mode   = M_SETTLE;
                            settle_load = 1'b1;
                        end
                    end
                end
                M_SETTLE: begin
                    if (settle_done) begin
                        st_d.mode = M_HIGH;
                        st_d.exc  = 1'b1;
                    end
                end
                default: st_d.mode = M_RESET;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge sys_rst_n_i) begin
        if (!sys_rst_n_i) begin
            st_q <= '{mode: M_RESET, ret: M_HIGH, exc: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    logic [4:0] gate;

    always_comb begin
        unique case (st_q.mode)
            M_HIGH, M_MED, M_SUB: gate = 5'b11110;
            M_SLEEP:              gate = 5'b01111;
            M_WATCH, M_SETTLE:    gate = 5'b00111;
            M_HWSTBY:             gate = 5'b00001;
            default:              gate = 5'b00011;
        endcase
    end

    assign mode_o       = st_q.mode;
    assign cpu_clk_en_o = gate[4];
    assign per_clk_en_o = gate[3];
    assign wdt_clk_en_o = gate[2];
    assign subosc_en_o  = gate[1];
    assign cpu_halt_o   = gate[0];
    assign exc_start_o  = st_q.exc;

    // R2: arriving in watch always follows a strobe that met every entry condition
    p_watch_entry_r2: assert property (@(posedge clk_i) disable iff (!sys_rst_n_i)
        ((st_q.mode == M_WATCH) && ($past(st_q.mode) != M_WATCH))
        |-> $past(sleep_i && watch_ok));

    // R5: leaving watch toward a run or settling mode needs an admissible source
    p_wake_src_r5: assert property (@(posedge clk_i) disable iff (!sys_rst_n_i)
        (($past(st_q.mode) == M_WATCH) &&
         (st_q.mode inside {M_HIGH, M_MED, M_SUB, M_SETTLE}))
        |-> $past(nmi_i || (!int_mask_i &&
                  ((|(irq_i & irq_en_i)) || (tmr_ovf_i && tmr_ovf_ie_i)))));

    // R7: the step from settling to high speed happens only once the counter has run out
    p_settle_end_r7: assert property (@(posedge clk_i) disable iff (!sys_rst_n_i)
        (($past(st_q.mode) == M_SETTLE) && (st_q.mode == M_HIGH))
        |-> ($past(settle_done) && exc_start_o));

    // R9: a low standby pin always lands in hardware standby
    p_hwstby_r9: assert property (@(posedge clk_i) disable iff (!sys_rst_n_i)
        !hw_stby_n_i |=> (st_q.mode == M_HWSTBY));

    // R11: the start-exception pulse lasts a single cycle
    p_exc_pulse_r11: assert property (@(posedge clk_i) disable iff (!sys_rst_n_i)
        exc_start_o |=> !exc_start_o);

endmodule

// File: tb/wmode_seq_tb.sv
`timescale 1ns/1ps
module wmode_seq_tb_top;

    logic       clk = 1'b0;
    logic       sys_rst_n = 1'b0;
    logic       aux_rst_n = 1'b1;
    logic       hw_stby_n = 1'b1;
    logic       sleep = 1'b0;
    logic       stby_sel = 1'b0;
    logic       direct_xfer = 1'b0;
    logic       tmr_clk_sel = 1'b0;
    logic       low_speed = 1'b0;
    logic [2:0] clk_div = '0;
    logic [2:0] settle_sel = '0;
    logic [7:0] irq = '0;
    logic [7:0] irq_en = '0;
    logic       tmr_ovf = 1'b0;
    logic       tmr_ovf_ie = 1'b0;
    logic       nmi = 1'b0;
    logic       int_mask = 1'b0;
    logic [2:0] mode;
    logic       cpu_en, per_en, wdt_en, sub_en, halt, exc;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    wmode_seq dut_i (
        .clk_i            (clk),
        .sys_rst_n_i      (sys_rst_n),
        .aux_rst_n_i      (aux_rst_n),
        .hw_stby_n_i      (hw_stby_n),
        .sleep_i          (sleep),
        .stby_sel_i       (stby_sel),
        .direct_xfer_i    (direct_xfer),
        .tmr_clk_sel_i    (tmr_clk_sel),
        .low_speed_wake_i (low_speed),
        .clk_div_i        (clk_div),
        .settle_sel_i     (settle_sel),
        .irq_i            (irq),
        .irq_en_i         (irq_en),
        .tmr_ovf_i        (tmr_ovf),
        .tmr_ovf_ie_i     (tmr_ovf_ie),
        .nmi_i            (nmi),
        .int_mask_i       (int_mask),
        .mode_o           (mode),
        .cpu_clk_en_o     (cpu_en),
        .per_clk_en_o     (per_en),
        .wdt_clk_en_o     (wdt_en),
        .subosc_en_o      (sub_en),
        .cpu_halt_o       (halt),
        .exc_start_o      (exc)
    );

    function automatic logic [4:0] exp_gate(input logic [2:0] m);
        case (m)
            3'd0, 3'd1, 3'd2: return 5'b11110;
            3'd3:             return 5'b01111;
            3'd4, 3'd5:       return 5'b00111;
            3'd6:             return 5'b00001;
            default:          return 5'b00011;
        endcase
    endfunction

    function automatic logic [2:0] exp_entry(input logic [2:0] m, input logic s,
                                             input logic d, input logic p,
                                             input logic [2:0] dv);
        if ((m == 3'd0 || m == 3'd2) && s && !d && p && dv == 3'd0) return 3'd4;
        return 3'd3;
    endfunction

    function automatic logic [2:0] exp_exit(input logic ls, input logic [2:0] dv);
        if (ls) return 3'd2;
        if (dv != 3'd0) return 3'd1;
        return 3'd5;
    endfunction

    task automatic chk(input string tag, input int act, input int expv);
        n_chk++;
        if (act != expv) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic chk_gate(input string tag);
        chk(tag, int'({cpu_en, per_en, wdt_en, sub_en, halt}), int'(exp_gate(mode)));
    endtask

    task automatic force_high();
        aux_rst_n = 1'b0;
        step();
        aux_rst_n = 1'b1;
        chk("R10 aux reset", int'(mode), 7);
        step();
        chk("R10 reset exit", int'(mode), 0);
    endtask

    task automatic enter_watch();
        stby_sel = 1'b1; direct_xfer = 1'b0; tmr_clk_sel = 1'b1; clk_div = 3'd0;
        sleep = 1'b1;
        step();
        sleep = 1'b0;
    endtask

    task automatic to_mode(input logic [2:0] m);
        force_high();
        if (m != 3'd0) begin
            enter_watch();
            low_speed = (m == 3'd2);
            clk_div   = (m == 3'd1) ? 3'd2 : 3'd0;
            nmi = 1'b1;
            step();
            nmi = 1'b0; low_speed = 1'b0; clk_div = 3'd0;
        end
        chk("R6 start mode", int'(mode), int'(m));
    endtask

    task automatic settle_measure(input int span, input bit noisy);
        int cnt = 1;
        chk("R6 settling entered", int'(mode), 5);
        chk_gate("R4 settling gates");
        while (mode == 3'd5 && cnt < 2000) begin
            if (noisy) begin
                nmi = cnt[0]; irq = 8'hFF; irq_en = 8'hFF; sleep = cnt[1];
                settle_sel = 3'(cnt);
            end
            step();
            if (mode == 3'd5) cnt++;
        end
        nmi = 1'b0; irq = '0; irq_en = '0; sleep = 1'b0;
        chk(noisy ? "R11 settle length with noise" : "R7 settle length", cnt, span);
        chk("R7 settle exit mode", int'(mode), 0);
        chk("R7 settle exit pulse", int'(exc), 1);
        step();
        chk("R11 pulse single", int'(exc), 0);
    endtask

    initial begin
        #(5.0 * 190000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        int r;
        r = $urandom(32'd20240611);
        step();
        // R1: reset state
        chk("R1 reset mode", int'(mode), 7);
        chk("R1 reset pulse", int'(exc), 0);
        chk_gate("R4 reset gates");
        sys_rst_n = 1'b1;
        step();
        chk("R1 first mode", int'(mode), 0);
        chk_gate("R4 high gates");

        // R5: filtering in watch
        enter_watch();
        chk("R2 directed watch", int'(mode), 4);
        chk_gate("R4 watch gates");
        irq = 8'h10; irq_en = 8'hEF;
        step();
        chk("R5 disabled line ignored", int'(mode), 4);
        irq_en = 8'h10; int_mask = 1'b1;
        step();
        chk("R5 masked line ignored", int'(mode), 4);
        irq = '0; irq_en = '0; tmr_ovf = 1'b1; tmr_ovf_ie = 1'b0; int_mask = 1'b0;
        step();
        chk("R5 timer disabled ignored", int'(mode), 4);
        tmr_ovf_ie = 1'b1; int_mask = 1'b1;
        step();
        chk("R5 timer masked ignored", int'(mode), 4);
        tmr_ovf = 1'b0; tmr_ovf_ie = 1'b0; nmi = 1'b1; low_speed = 1'b1;
        step();
        nmi = 1'b0; int_mask = 1'b0; low_speed = 1'b0;
        chk("R5 nmi under mask wakes", int'(mode), 2);
        chk("R6 sub pulse", int'(exc), 1);
        step();
        chk("R11 pulse single", int'(exc), 0);

        // R5: timer overflow wake into medium
        enter_watch();
        tmr_ovf = 1'b1; tmr_ovf_ie = 1'b1; clk_div = 3'd3;
        step();
        tmr_ovf = 1'b0; tmr_ovf_ie = 1'b0; clk_div = 3'd0;
        chk("R5 timer wake to medium", int'(mode), 1);

        // R11: settling with noise at the longest span
        force_high();
        enter_watch();
        settle_sel = 3'd7; nmi = 1'b1;
        step();
        nmi = 1'b0;
        settle_measure(1024, 1'b1);
        settle_sel = '0;

        // R9: hardware standby from watch
        enter_watch();
        hw_stby_n = 1'b0;
        step();
        chk("R9 standby mode", int'(mode), 6);
        chk_gate("R4 standby gates");
        nmi = 1'b1; aux_rst_n = 1'b0;
        step(); step();
        chk("R9 standby held", int'(mode), 6);
        nmi = 1'b0; aux_rst_n = 1'b1; hw_stby_n = 1'b1;
        step();
        chk("R9 standby exit reset", int'(mode), 7);
        step();
        chk("R9 standby to high", int'(mode), 0);

        // R10: second reset pin from watch
        enter_watch();
        aux_rst_n = 1'b0;
        step();
        aux_rst_n = 1'b1;
        chk("R10 watch to reset", int'(mode), 7);
        step();
        chk("R10 back to high", int'(mode), 0);

        // random trials over entry and exit
        for (int it = 0; it < 30; it++) begin
            logic [2:0] start, ent, tgt;
            int k;
            start = 3'($urandom % 3);
            to_mode(start);
            stby_sel    = 1'($urandom);
            direct_xfer = 1'($urandom);
            tmr_clk_sel = 1'($urandom);
            clk_div     = ($urandom % 2 == 0) ? 3'd0 : 3'(1 + $urandom % 7);
            ent = exp_entry(start, stby_sel, direct_xfer, tmr_clk_sel, clk_div);
            sleep = 1'b1;
            step();
            sleep = 1'b0;
            chk(ent == 3'd4 ? "R2 random entry" : "R3 random fallback", int'(mode), int'(ent));
            chk_gate("R4 random gates");
            low_speed  = 1'($urandom);
            clk_div    = ($urandom % 2 == 0) ? 3'd0 : 3'(1 + $urandom % 7);
            settle_sel = 3'($urandom % 8);
            if (ent == 3'd3) begin
                k = $urandom % 8;
                irq[k] = 1'b1; irq_en[k] = 1'b1;
                step();
                irq = '0; irq_en = '0;
                chk("R8 sleep return mode", int'(mode), int'(start));
                chk("R8 sleep wake pulse", int'(exc), 1);
                step();
                chk("R11 pulse single", int'(exc), 0);
            end else begin
                tgt = exp_exit(low_speed, clk_div);
                k = 8 << settle_sel;
                nmi = 1'b1;
                step();
                nmi = 1'b0;
                if (tgt == 3'd5) begin
                    settle_measure(k, 1'b0);
                end else begin
                    chk("R6 exit target", int'(mode), int'(tgt));
                    chk("R6 exit pulse", int'(exc), 1);
                    step();
                    chk("R11 pulse single", int'(exc), 0);
                end
            end
            low_speed = 1'b0; clk_div = '0; settle_sel = '0;
            stby_sel = 1'b0; direct_xfer = 1'b0; tmr_clk_sel = 1'b0;
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule